// File: doc/BRIEF.md
# Boundary-Scan Test Controller for a 20-Bit Dual-Port Transceiver

This block is the serial test logic that sits between a four-wire test port and the pads of a 20-bit, two-port bidirectional transceiver. The four wires are a test clock, a mode select, a serial input and a serial output. A 16-state controller walks through the standard capture, shift and update phases. An 8-bit instruction register picks one of four serial data paths: a one-bit bypass stage, a 32-bit identification word, a 48-cell boundary chain or a 3-bit control chain. Several instruction codes share a path.

In normal-mode instructions the core's port data and active-low enables reach the pads unchanged. In test-mode instructions the pad values and enables come from the boundary chain's update stage instead. The chain has one cell per pad, and one control cell per port gates all 20 drivers of that port. A high-impedance instruction turns both ports off while the one-bit path stays in the scan loop.

Shifting and capture happen on the rising test-clock edge. The serial output, its enable and every update stage change on the falling edge.

Top module: `bscan_tap_ctrl`

## Requirements
- R1: Five rising edges with the mode select high bring the controller to its reset state from any state. That state makes the identification code (0x81) the current instruction and returns the pads to the normal-mode pass-through.
- R2: The instruction chain is 8 bits long and is shifted LSB first toward the serial output. In its capture phase it loads 8'b10000001.
- R3: Under the identification instruction the data chain reads 32'h3001D02F, LSB first. Its fields are version 4'b0011, part 16'h001D, maker 11'b00000010111 and a final 1.
- R4: The serial path length per code is as follows. 0xFF, 0x84, 0x06, 0x87, 0x09 and 0x8D select 1 bit, and so does every code not listed here. 0x81 selects 32 bits. 0x00, 0x82, 0x0A, 0x8B and 0x0C select 48 bits. 0x8E and 0x0F select 3 bits.
- R5: The boundary capture loads cells 0-19 from B-port pads 1-20, cells 20-39 from A-port pads 1-20, cells 40-45 from control observe inputs bit 0-5, cell 46 from the A active-low enable and cell 47 from the B active-low enable. Cell 0 is nearest the serial output.
- R6: Under codes 0xFF, 0x84, 0x82, 0x81, 0x0A, 0x0C and 0x8E, and any unlisted code, the pad data equals the core data and each pad enable equals the inverse of its core active-low enable.
- R7: Under codes 0x00, 0x87, 0x09, 0x8B, 0x8D and 0x0F the A pads take update cells 20-39 and the B pads take cells 0-19. The A enable is the inverse of update cell 46 and the B enable is the inverse of update cell 47, so a 1 in a control cell turns its port off.
- R8: Under code 0x06 both pad enables are low.
- R9: The serial output enable is high only while in a shift state, and the serial output changes on the falling test-clock edge.
- R10: Update stages change only on the falling edge in an update state. A scan through the one-bit path leaves the pads unchanged.
- R11: The 3-bit control chain captures its own update stage, so a value written by one scan is read back by the next.
- R12: The active-low reset, sampled on test-clock edges, puts the controller in its reset state. It also clears the serial output enable and sets both control cells to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | Serial output enable |
| pin_a_in | input | 20 | Observed A-port pad values |
| pin_b_in | input | 20 | Observed B-port pad values |
| ctl_obs_in | input | 6 | Observed transceiver control inputs |
| core_a_dat | input | 20 | Core data for A pads |
| core_b_dat | input | 20 | Core data for B pads |
| core_oe_a_n | input | 1 | Core active-low enable, A port |
| core_oe_b_n | input | 1 | Core active-low enable, B port |
| pad_a_dat | output | 20 | Data to A pad drivers |
| pad_a_oe | output | 1 | A pad driver enable, active high |
| pad_b_dat | output | 20 | Data to B pad drivers |
| pad_b_oe | output | 1 | B pad driver enable, active high |

## Verification
The controller state advances on each rising edge. A shifted bit therefore appears on the serial output at the falling edge after the rising edge that entered the shift state, and one more falling edge is needed for each further bit. The bench drives the mode select and serial input 2 ns after a falling edge and samples the serial output and its enable 10 ns after that edge, ahead of the next rising edge. Instruction and boundary updates land on the falling edge inside the update state, so the pads settle before the rising edge that leaves that state. Pad checks run 1 ns after each scan sequence returns to idle.

// File: rtl/bscan_pkg.sv
// Package: shared types, opcodes and decode for the boundary-scan controller.
// Assumes an 8-bit instruction register; all other widths come from the top.
package bscan_pkg;

    localparam int IR_W = 8;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_ONEBIT, PATH_IDENT, PATH_BOUND, PATH_CTL
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     test_mode;
        logic     force_off;
    } instr_dec_t;

    localparam logic [IR_W-1:0] IR_CAPTURE_VAL    = 8'b1000_0001;
    localparam logic [IR_W-1:0] OP_EXTEST         = 8'b0000_0000;
    localparam logic [IR_W-1:0] OP_SAMPLE         = 8'b1000_0010;
    localparam logic [IR_W-1:0] OP_IDCODE         = 8'b1000_0001;
    localparam logic [IR_W-1:0] OP_HIGHZ          = 8'b0000_0110;
    localparam logic [IR_W-1:0] OP_CLAMP          = 8'b1000_0111;
    localparam logic [IR_W-1:0] OP_RUN_SELFCHK    = 8'b0000_1001;
    localparam logic [IR_W-1:0] OP_BREAD_NORM     = 8'b0000_1010;
    localparam logic [IR_W-1:0] OP_BREAD_TEST     = 8'b1000_1011;
    localparam logic [IR_W-1:0] OP_CELL_CHECK     = 8'b0000_1100;
    localparam logic [IR_W-1:0] OP_TOGGLE_TEST    = 8'b1000_1101;
    localparam logic [IR_W-1:0] OP_CTLSCAN_NORM   = 8'b1000_1110;
    localparam logic [IR_W-1:0] OP_CTLSCAN_TEST   = 8'b0000_1111;

    // Map an opcode onto its data path and pad mode; unlisted codes fall to the one-bit path.
    function automatic instr_dec_t decode_op(input logic [IR_W-1:0] op);
        instr_dec_t d;
        d = '{path: PATH_ONEBIT, test_mode: 1'b0, force_off: 1'b0};
        case (op)
            OP_EXTEST:       d = '{path: PATH_BOUND,  test_mode: 1'b1, force_off: 1'b0};
            OP_SAMPLE:       d = '{path: PATH_BOUND,  test_mode: 1'b0, force_off: 1'b0};
            OP_IDCODE:       d = '{path: PATH_IDENT,  test_mode: 1'b0, force_off: 1'b0};
            OP_HIGHZ:        d = '{path: PATH_ONEBIT, test_mode: 1'b1, force_off: 1'b1};
            OP_CLAMP:        d = '{path: PATH_ONEBIT, test_mode: 1'b1, force_off: 1'b0};
            OP_RUN_SELFCHK:  d = '{path: PATH_ONEBIT, test_mode: 1'b1, force_off: 1'b0};
            OP_BREAD_NORM:   d = '{path: PATH_BOUND,  test_mode: 1'b0, force_off: 1'b0};
            OP_BREAD_TEST:   d = '{path: PATH_BOUND,  test_mode: 1'b1, force_off: 1'b0};
            OP_CELL_CHECK:   d = '{path: PATH_BOUND,  test_mode: 1'b0, force_off: 1'b0};
            OP_TOGGLE_TEST:  d = '{path: PATH_ONEBIT, test_mode: 1'b1, force_off: 1'b0};
            OP_CTLSCAN_NORM: d = '{path: PATH_CTL,    test_mode: 1'b0, force_off: 1'b0};
            OP_CTLSCAN_TEST: d = '{path: PATH_CTL,    test_mode: 1'b1, force_off: 1'b0};
            default:         d = '{path: PATH_ONEBIT, test_mode: 1'b0, force_off: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bscan_tap_fsm.sv
// Module: 16-state test-port controller. Advances on the rising test clock.
// Assumes trst_n is synchronous to tck and held low for at least one edge.
module bscan_tap_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state selection from the mode-select input.
    always_comb begin
        nxt = state;
        case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

endmodule

// File: rtl/bscan_instr_reg.sv
// Module: instruction chain with capture/shift on the rising edge and a
// falling-edge update stage; decodes the current opcode.
// Assumes the controller state comes from bscan_tap_fsm.
module bscan_instr_reg
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_so,
    output logic [IR_W-1:0] ir_sr,
    output instr_dec_t dec
);

    logic [IR_W-1:0] ir_cur;

    // Capture the fixed pattern or shift one bit toward the serial output.
    always_ff @(posedge tck) begin
        if (state == ST_CAP_IR)     ir_sr <= IR_CAPTURE_VAL;
        else if (state == ST_SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Current instruction: identification code on reset, new opcode on update.
    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_RESET) ir_cur <= OP_IDCODE;
        else if (state == ST_UPD_IR)      ir_cur <= ir_sr;
    end

    assign ir_so = ir_sr[0];
    assign dec   = decode_op(ir_cur);

endmodule

// File: rtl/bscan_dr_chain.sv
// Module: generic data chain of W cells. Each cell captures a parallel value
// or takes its upper neighbour on the rising edge; the update stage copies
// the chain on the falling edge. Cell 0 feeds the serial output.
module bscan_dr_chain #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    UPD_RST = '0
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         cap_en,
    input  logic         shift_en,
    input  logic         upd_en,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic         so,
    output logic [W-1:0] upd_q
);

    logic [W-1:0] sr;
    logic [W-1:0] shin;

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i == W - 1) begin : g_top
            assign shin[i] = tdi;
        end else begin : g_mid
            assign shin[i] = sr[i+1];
        end

        // Per-cell capture or shift stage.
        always_ff @(posedge tck) begin
            if (cap_en)        sr[i] <= cap_val[i];
            else if (shift_en) sr[i] <= shin[i];
        end
    end

    // Update stage, loaded on the falling edge in the update state.
    always_ff @(negedge tck) begin
        if (!trst_n)     upd_q <= UPD_RST;
        else if (upd_en) upd_q <= sr;
    end

    assign so = sr[0];

endmodule

// File: rtl/bscan_tap_ctrl.sv
// Module: top of the boundary-scan controller. Routes the serial path through
// the one-bit, identification, boundary or control chain and selects the
// pad data and enables from the core or from the boundary update stage.
// Assumes all test inputs are synchronous to tck.
module bscan_tap_ctrl
    import bscan_pkg::*;
#(
    parameter int          PORT_W   = 20,
    parameter int          CTL_OBS  = 6,
    parameter int          CTL_W    = 3,
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h3001_D02F
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_en,
    input  logic [PORT_W-1:0] pin_a_in,
    input  logic [PORT_W-1:0] pin_b_in,
    input  logic [CTL_OBS-1:0] ctl_obs_in,
    input  logic [PORT_W-1:0] core_a_dat,
    input  logic [PORT_W-1:0] core_b_dat,
    input  logic              core_oe_a_n,
    input  logic              core_oe_b_n,
    output logic [PORT_W-1:0] pad_a_dat,
    output logic              pad_a_oe,
    output logic [PORT_W-1:0] pad_b_dat,
    output logic              pad_b_oe
);

    localparam int BSR_N    = 2 * PORT_W + CTL_OBS + 2;
    localparam int CELL_CA  = BSR_N - 2;
    localparam int CELL_CB  = BSR_N - 1;
    localparam logic [BSR_N-1:0] BSR_RST = {2'b11, {(BSR_N-2){1'b0}}};

    tap_state_e      tap_state;
    instr_dec_t      dec;
    logic            ir_so;
    logic [IR_W-1:0] ir_sr;

    logic cap_dr, sh_dr, upd_dr;
    logic sel_bound, sel_ctl;
    logic bsr_so, ctl_so, dr_so;
    logic byp_q;
    logic [ID_W-1:0]  id_sr;
    logic [BSR_N-1:0] bsr_cap, bsr_upd;
    logic [CTL_W-1:0] ctl_upd;

    bscan_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (tap_state)
    );

    bscan_instr_reg u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (tap_state),
        .tdi    (tdi),
        .ir_so  (ir_so),
        .ir_sr  (ir_sr),
        .dec    (dec)
    );

    assign cap_dr    = (tap_state == ST_CAP_DR);
    assign sh_dr     = (tap_state == ST_SH_DR);
    assign upd_dr    = (tap_state == ST_UPD_DR);
    assign sel_bound = (dec.path == PATH_BOUND);
    assign sel_ctl   = (dec.path == PATH_CTL);

    assign bsr_cap = {core_oe_b_n, core_oe_a_n, ctl_obs_in, pin_a_in, pin_b_in};

    bscan_dr_chain #(.W(BSR_N), .UPD_RST(BSR_RST)) u_bsr (
        .tck      (tck),
        .trst_n   (trst_n),
        .cap_en   (cap_dr & sel_bound),
        .shift_en (sh_dr & sel_bound),
        .upd_en   (upd_dr & sel_bound),
        .tdi      (tdi),
        .cap_val  (bsr_cap),
        .so       (bsr_so),
        .upd_q    (bsr_upd)
    );

    bscan_dr_chain #(.W(CTL_W), .UPD_RST('0)) u_ctl (
        .tck      (tck),
        .trst_n   (trst_n),
        .cap_en   (cap_dr & sel_ctl),
        .shift_en (sh_dr & sel_ctl),
        .upd_en   (upd_dr & sel_ctl),
        .tdi      (tdi),
        .cap_val  (ctl_upd),
        .so       (ctl_so),
        .upd_q    (ctl_upd)
    );

    // One-bit path: clears on capture, follows the serial input on shift.
    always_ff @(posedge tck) begin
        if (cap_dr && dec.path == PATH_ONEBIT)     byp_q <= 1'b0;
        else if (sh_dr && dec.path == PATH_ONEBIT) byp_q <= tdi;
    end

    // Identification chain: loads the fixed word, then shifts toward the output.
    always_ff @(posedge tck) begin
        if (cap_dr && dec.path == PATH_IDENT)     id_sr <= ID_VALUE[ID_W-1:0];
        else if (sh_dr && dec.path == PATH_IDENT) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Serial-out selection among the four data paths.
    always_comb begin
        case (dec.path)
            PATH_IDENT: dr_so = id_sr[0];
            PATH_BOUND: dr_so = bsr_so;
            PATH_CTL:   dr_so = ctl_so;
            default:    dr_so = byp_q;
        endcase
    end

    // Serial output and its enable, retimed to the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= (tap_state == ST_SH_IR) ? ir_so : dr_so;
            tdo_en <= (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);
        end
    end

    // Pad source: core in normal mode, boundary update stage in test mode.
    always_comb begin
        if (dec.test_mode) begin
            pad_a_dat = bsr_upd[2*PORT_W-1:PORT_W];
            pad_b_dat = bsr_upd[PORT_W-1:0];
            pad_a_oe  = ~bsr_upd[CELL_CA] & ~dec.force_off;
            pad_b_oe  = ~bsr_upd[CELL_CB] & ~dec.force_off;
        end else begin
            pad_a_dat = core_a_dat;
            pad_b_dat = core_b_dat;
            pad_a_oe  = ~core_oe_a_n;
            pad_b_oe  = ~core_oe_b_n;
        end
    end

endmodule

// File: rtl/bscan_tap_ctrl_chk.sv
// Module: assertion checker bound to bscan_tap_ctrl.
module bscan_tap_ctrl_chk
    import bscan_pkg::*;
#(
    parameter int PW = 20
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_e      state,
    input logic            tdo_en,
    input instr_dec_t      dec,
    input logic [IR_W-1:0] ir_sr,
    input logic [PW-1:0]   pad_a_dat,
    input logic [PW-1:0]   pad_b_dat,
    input logic            pad_a_oe,
    input logic            pad_b_oe,
    input logic [PW-1:0]   core_a_dat,
    input logic [PW-1:0]   core_b_dat,
    input logic            core_oe_a_n,
    input logic            core_oe_b_n
);

    logic [2:0] ones_cnt;

    // Count consecutive rising edges with the mode select high, saturating.
    always_ff @(posedge tck) begin
        if (!trst_n)            ones_cnt <= '0;
        else if (!tms)          ones_cnt <= '0;
        else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
    end

    // R1
    tlr_after_five_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt >= 3'd5) |-> (state == ST_RESET));

    // R2
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE_VAL));

    // R6
    normal_pass_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !dec.test_mode |-> (pad_a_dat == core_a_dat && pad_b_dat == core_b_dat &&
                            pad_a_oe == !core_oe_a_n && pad_b_oe == !core_oe_b_n));

    // R8
    highz_off_chk: assert property (@(posedge tck) disable iff (!trst_n)
        dec.force_off |-> (!pad_a_oe && !pad_b_oe));

    // R9
    tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind bscan_tap_ctrl bscan_tap_ctrl_chk #(.PW(PORT_W)) u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .state       (tap_state),
    .tdo_en      (tdo_en),
    .dec         (dec),
    .ir_sr       (ir_sr),
    .pad_a_dat   (pad_a_dat),
    .pad_b_dat   (pad_b_dat),
    .pad_a_oe    (pad_a_oe),
    .pad_b_oe    (pad_b_oe),
    .core_a_dat  (core_a_dat),
    .core_b_dat  (core_b_dat),
    .core_oe_a_n (core_oe_a_n),
    .core_oe_b_n (core_oe_b_n)
);

// File: tb/bscan_tap_ctrl_tb.sv
`timescale 1ns/1ps
module bscan_tap_ctrl_tb;

    localparam real TCK_PERIOD = 25.0;
    localparam logic [31:0] EXP_ID = 32'h3001_D02F;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo, tdo_en;
    logic [19:0] pin_a_in = '0, pin_b_in = '0, core_a_dat = '0, core_b_dat = '0;
    logic [5:0]  ctl_obs_in = '0;
    logic        core_oe_a_n = 1'b0, core_oe_b_n = 1'b0;
    logic [19:0] pad_a_dat, pad_b_dat;
    logic        pad_a_oe, pad_b_oe;

    int checks = 0;
    int errors = 0;
    logic [47:0] bsr_m = {2'b11, 46'b0};

    bscan_tap_ctrl u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pin_a_in(pin_a_in), .pin_b_in(pin_b_in), .ctl_obs_in(ctl_obs_in),
        .core_a_dat(core_a_dat), .core_b_dat(core_b_dat),
        .core_oe_a_n(core_oe_a_n), .core_oe_b_n(core_oe_b_n),
        .pad_a_dat(pad_a_dat), .pad_a_oe(pad_a_oe),
        .pad_b_dat(pad_b_dat), .pad_b_oe(pad_b_oe)
    );

    always #(TCK_PERIOD/2.0) tck = ~tck;

    initial begin
        #(TCK_PERIOD * 150000.0);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int exp_len(input logic [7:0] op);
        case (op)
            8'h81:                                 return 32;
            8'h00, 8'h82, 8'h0A, 8'h8B, 8'h0C:     return 48;
            8'h8E, 8'h0F:                          return 3;
            default:                               return 1;
        endcase
    endfunction

    function automatic bit exp_test(input logic [7:0] op);
        case (op)
            8'h00, 8'h06, 8'h87, 8'h09, 8'h8B, 8'h8D, 8'h0F: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic oe);
        @(negedge tck);
        #2;
        tms = m;
        tdi = d;
        #8;
        o  = tdo;
        oe = tdo_en;
        @(posedge tck);
    endtask

    task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
        logic o, oe;
        step(1, 0, o, oe); step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i], o, oe);
            cap[i] = o;
        end
        step(1, 0, o, oe); step(0, 0, o, oe);
        #1;
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout, output bit en_ok);
        logic o, oe;
        dout = '0;
        en_ok = 1'b1;
        step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, oe);
            dout[i] = o;
            if (oe !== 1'b1) en_ok = 1'b0;
        end
        step(1, 0, o, oe); step(0, 0, o, oe);
        #1;
    endtask

    task automatic track_bsr(input int n, input logic [63:0] din);
        for (int j = 0; j < 48; j++) bsr_m[j] = din[n - 48 + j];
    endtask

    task automatic check_len(input logic [7:0] op, input string req);
        logic [63:0] din, dout;
        bit en_ok;
        int len, bad;
        len = exp_len(op);
        din = {$urandom, $urandom};
        scan_dr(64, din, dout, en_ok);
        if (len == 48) track_bsr(64, din);
        bad = 0;
        for (int i = 0; i < 64 - len; i++) if (dout[i + len] !== din[i]) bad++;
        chk(bad == 0, req, 64'(bad), 64'(0));
        chk(en_ok, "R9 tdo_en during shift", 64'(en_ok), 64'(1));
    endtask

    task automatic rand_core();
        core_a_dat  = 20'($urandom);
        core_b_dat  = 20'($urandom);
        core_oe_a_n = 1'($urandom);
        core_oe_b_n = 1'($urandom);
        #1;
    endtask

    task automatic check_pins(input logic [7:0] op, input string req);
        logic [63:0] act, exp;
        act = {22'b0, pad_a_oe, pad_b_oe, pad_a_dat, pad_b_dat};
        if (op == 8'h06) begin
            act = {62'b0, pad_a_oe, pad_b_oe};
            exp = 64'b0;
        end else if (exp_test(op)) begin
            exp = {22'b0, ~bsr_m[46], ~bsr_m[47], bsr_m[39:20], bsr_m[19:0]};
        end else begin
            exp = {22'b0, ~core_oe_a_n, ~core_oe_b_n, core_a_dat, core_b_dat};
        end
        chk(act === exp, req, act, exp);
    endtask

    logic [7:0]  op_list [13] = '{8'hFF, 8'h84, 8'h00, 8'h82, 8'h81, 8'h06, 8'h87,
                                  8'h09, 8'h0A, 8'h8B, 8'h0C, 8'h8D, 8'h8E};

    initial begin
        logic [7:0]  cap;
        logic [63:0] din, dout;
        logic [47:0] capv;
        logic [41:0] pads_before;
        logic        o, oe;
        bit          en_ok;

        void'($urandom(32'd1149));

        // R12: reset held over several edges
        repeat (3) @(posedge tck);
        @(negedge tck); #2; trst_n = 1'b1;
        step(0, 0, o, oe);
        #1;
        rand_core();
        chk(tdo_en === 1'b0, "R12 tdo_en after reset", 64'(tdo_en), 64'(0));
        check_pins(8'h81, "R12/R6 pass-through after reset");

        // R3, R1: identification word is current after reset
        scan_dr(32, 64'h0, dout, en_ok);
        chk(dout[31:0] === EXP_ID, "R3 ident word", dout, 64'(EXP_ID));
        chk(tdo_en === 1'b0, "R9 tdo_en idle", 64'(tdo_en), 64'(0));

        // R2: instruction capture pattern
        scan_ir(8'h82, cap);
        chk(cap === 8'b1000_0001, "R2 IR capture", 64'(cap), 64'h81);

        // R5: boundary capture order
        pin_a_in = 20'($urandom); pin_b_in = 20'($urandom); ctl_obs_in = 6'($urandom);
        rand_core();
        capv = {core_oe_b_n, core_oe_a_n, ctl_obs_in, pin_a_in, pin_b_in};
        din = {16'b0, 48'($urandom) ^ {$urandom, 16'b0}};
        scan_dr(48, din, dout, en_ok);
        track_bsr(48, din);
        chk(dout[47:0] === capv, "R5 boundary capture", dout, 64'(capv));
        check_pins(8'h82, "R6 pass-through under sample");

        // R7, R8, R10: control cell combinations across test-mode codes
        for (int k = 0; k < 4; k++) begin
            scan_ir(8'h82, cap);
            din = {16'b0, k[1:0], 46'({$urandom, $urandom})};
            scan_dr(48, din, dout, en_ok);
            track_bsr(48, din);
            scan_ir(8'h00, cap);
            rand_core();
            check_pins(8'h00, "R7 preset pads");
            scan_ir(8'h06, cap);
            check_pins(8'h06, "R8 all drivers off");
            check_len(8'h06, "R4 length under highz");
            scan_ir(8'h87, cap);
            check_pins(8'h87, "R7 clamp from update stage");
            pads_before = {pad_a_oe, pad_b_oe, pad_a_dat, pad_b_dat};
            scan_dr(16, {$urandom, $urandom}, dout, en_ok);
            chk({pad_a_oe, pad_b_oe, pad_a_dat, pad_b_dat} === pads_before,
                "R10 pads hold over one-bit scan",
                64'({pad_a_oe, pad_b_oe, pad_a_dat, pad_b_dat}), 64'(pads_before));
        end

        // R4, R6, R7, R8: opcodes in random order, with random unlisted codes
        for (int t = 0; t < 30; t++) begin
            logic [7:0] op;
            op = (t % 3 == 2) ? 8'($urandom) : op_list[$urandom % 13];
            if (t == 0) op = 8'h0F;
            scan_ir(op, cap);
            check_len(op, "R4 path length");
            rand_core();
            check_pins(op, exp_test(op) ? "R7 test-mode pads" : "R6 normal pads");
        end

        // R11: control chain reads back what was written
        scan_ir(8'h8E, cap);
        scan_dr(3, 64'b101, dout, en_ok);
        scan_dr(3, 64'b010, dout, en_ok);
        chk(dout[2:0] === 3'b101, "R11 control readback", dout, 64'b101);
        scan_dr(3, 64'b000, dout, en_ok);
        chk(dout[2:0] === 3'b010, "R11 control readback second", dout, 64'b010);

        // R1: five high mode-select edges from inside a shift
        scan_ir(8'h00, cap);
        step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
        repeat (5) step(1, 0, o, oe);
        step(0, 0, o, oe);
        #1;
        rand_core();
        check_pins(8'h81, "R1 pass-through after forced reset");
        scan_dr(32, 64'h0, dout, en_ok);
        chk(dout[31:0] === EXP_ID, "R1 ident current after forced reset", dout, 64'(EXP_ID));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule